// File: doc/BRIEF.md
# Accumulator Processor with Sequential Multiplier

This block is a small multi-cycle processor built around one 16-bit accumulator. A single array of 256 words of 16 bits holds both the program and its data. Each instruction is one word. The high byte is the address of an operand in the same array, and the low byte selects the operation. A controller takes each instruction through a fetch step and an execute step. Multiplication is the exception: the controller passes it to a separate shift-and-add unit over a start/done handshake and waits until that unit finishes.

A program is placed in the array through a streaming preload port while reset is held. When reset is released, execution starts at address 0x01. The program ends itself with an unconditional jump to its own address. This raises the halted flag and freezes the core. The accumulator, the program counter and the halted flag are plain observation outputs.

The preload port follows valid/ready rules. `ld_ready` is high only while `rst` is high. A word is written only in a cycle where `ld_valid` and `ld_ready` are both high. A word offered while ready is low is dropped, not delayed: the core owns the array once it runs, so the source must not count that word as delivered.

Top module: `acc_cpu_top`

## Requirements
- R1: After reset the accumulator is 0x0000, the program counter is 0x01 and halted is low. Every instruction that is not a jump and not a halt advances the program counter by exactly one.
- R2: ADD (low byte 0x01) replaces the accumulator with the accumulator plus the word at the operand address, modulo 2^16. OR (0x02) replaces it with the bitwise OR of the two.
- R3: LOAD (0x05) copies the word at the operand address into the accumulator. STORE (0x06) writes the accumulator to the operand address and leaves the accumulator unchanged. A stored word is seen by every later read of that address, including the fetch of an instruction.
- R4: NEG (0x0A) replaces the accumulator with its two's complement (inverted, plus one, modulo 2^16). Its high byte has no effect.
- R5: JUMP (0x03) to an address other than its own loads the program counter with the operand address. JUMPZ (0x04) does so only when the accumulator is zero; otherwise it advances by one.
- R6: A JUMP whose operand address equals its own address raises halted. After that, the program counter, the accumulator and halted never change until reset.
- R7: MULL (0x09) replaces the accumulator with the 16-bit unsigned product of the accumulator's low byte and the operand word's low byte.
- R8: Counted in rising clock edges from reset release, every instruction except MULL takes 2 cycles. MULL takes 11 cycles, because the controller stalls for the 8 multiplier steps and one handoff cycle.
- R9: Any low byte not listed above acts as a no-op that only advances the program counter.
- R10: `ld_ready` equals `rst`. The array is written from the preload port only when `ld_valid` and `ld_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the preload port |
| ld_valid | input | 1 | Preload word offered |
| ld_ready | output | 1 | Preload word accepted this cycle (high during reset) |
| ld_addr | input | 8 | Preload word address |
| ld_data | input | 16 | Preload word value |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 8 | Program counter |
| halted_o | output | 1 | Program has reached its self-jump |

## Verification
Two functions fall on the same clock edge when a STORE writes into the array: that edge also moves the program counter onto the next word. If the STORE targets that next word, the next fetch must return the freshly written value. The bench provokes this with a program that overwrites its own next instruction, turning one LOAD into a LOAD of a different address. It judges the result by the final accumulator and by the cycle count to halt. A second pairing comes from the preload port: the bench offers a word after reset release into an address the running program reads, and a correct final accumulator shows that the word was dropped.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int OP_W   = DATA_W - ADDR_W;

  localparam logic [OP_W-1:0] OP_ADD   = 8'h01;
  localparam logic [OP_W-1:0] OP_OR    = 8'h02;
  localparam logic [OP_W-1:0] OP_JUMP  = 8'h03;
  localparam logic [OP_W-1:0] OP_JUMPZ = 8'h04;
  localparam logic [OP_W-1:0] OP_LOAD  = 8'h05;
  localparam logic [OP_W-1:0] OP_STORE = 8'h06;
  localparam logic [OP_W-1:0] OP_MULL  = 8'h09;
  localparam logic [OP_W-1:0] OP_NEG   = 8'h0A;

  typedef enum logic [1:0] {
    S_FETCH = 2'd0,
    S_EXEC  = 2'd1,
    S_MWAIT = 2'd2,
    S_HALT  = 2'd3
  } cpu_state_t;
endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words_q[waddr] <= wdata;
  end

  assign rdata_a = words_q[raddr_a];
  assign rdata_b = words_q[raddr_b];
endmodule

// File: rtl/acc_cpu_mult.sv
module acc_cpu_mult #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic [2*W-1:0] mcand_q, sum_q;
  logic [W-1:0]   mplier_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      sum_q    <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      mcand_q  <= {{W{1'b0}}, a};
      mplier_q <= b;
      sum_q    <= '0;
      cnt_q    <= CW'(W);
      busy     <= 1'b1;
      done     <= 1'b0;
    end else if (busy) begin
      if (mplier_q[0]) sum_q <= sum_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign prod = sum_q;

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] fetch_word,
  input  logic [DW-1:0] oper_word,
  input  logic          mul_done,
  input  logic [DW-1:0] mul_prod,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] oper_addr,
  output logic [DW-1:0] acc,
  output logic          halted,
  output logic          mem_we,
  output logic          mul_start
);
  localparam int OW = DW - AW;

  cpu_state_t    state_q, state_d;
  logic [DW-1:0] ir_q, ir_d, acc_d;
  logic [AW-1:0] pc_d;
  logic          halt_d;
  logic [OW-1:0] op;

  assign op        = ir_q[OW-1:0];
  assign oper_addr = ir_q[DW-1:OW];

  always_comb begin
    state_d   = state_q;
    ir_d      = ir_q;
    pc_d      = pc;
    acc_d     = acc;
    halt_d    = halted;
    mem_we    = 1'b0;
    mul_start = 1'b0;
    case (state_q)
      S_FETCH: begin
        ir_d    = fetch_word;
        state_d = S_EXEC;
      end
      S_EXEC: begin
        state_d = S_FETCH;
        pc_d    = pc + AW'(1);
        case (op)
          OP_ADD:   acc_d = acc + oper_word;
          OP_OR:    acc_d = acc | oper_word;
          OP_LOAD:  acc_d = oper_word;
          OP_STORE: mem_we = 1'b1;
          OP_NEG:   acc_d = ~acc + DW'(1);
          OP_JUMP: begin
            if (oper_addr == pc) begin
              halt_d  = 1'b1;
              pc_d    = pc;
              state_d = S_HALT;
            end else begin
              pc_d = oper_addr;
            end
          end
          OP_JUMPZ: if (acc == '0) pc_d = oper_addr;
          OP_MULL: begin
            mul_start = 1'b1;
            pc_d      = pc;
            state_d   = S_MWAIT;
          end
          default: ;
        endcase
      end
      S_MWAIT: begin
        if (mul_done) begin
          acc_d   = mul_prod;
          pc_d    = pc + AW'(1);
          state_d = S_FETCH;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      ir_q    <= '0;
      pc      <= AW'(1);
      acc     <= '0;
      halted  <= 1'b0;
    end else begin
      state_q <= state_d;
      ir_q    <= ir_d;
      pc      <= pc_d;
      acc     <= acc_d;
      halted  <= halt_d;
    end
  end

  // R1
  add_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_EXEC && op == OP_ADD) |=> (pc - $past(pc)) == AW'(1));
  // R5
  jumpz_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_EXEC && op == OP_JUMPZ && acc != '0) |=> (pc - $past(pc)) == AW'(1));
  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && $stable(acc));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_MWAIT && !mul_done) |=> $stable(acc) && $stable(pc));
endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
  import acc_cpu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] acc_o,
  output logic [AW-1:0] pc_o,
  output logic          halted_o
);
  logic [DW-1:0] fetch_word, oper_word, mul_prod;
  logic [AW-1:0] oper_addr, waddr;
  logic [DW-1:0] wdata;
  logic          core_we, pre_we, we, mul_start, mul_done, mul_busy;

  assign ld_ready = rst;
  assign pre_we   = ld_valid & ld_ready;
  assign we       = pre_we | (core_we & ~rst);
  assign waddr    = pre_we ? ld_addr : oper_addr;
  assign wdata    = pre_we ? ld_data : acc_o;

  acc_cpu_mem #(.DW(DW), .AW(AW)) mem_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_a(pc_o), .rdata_a(fetch_word),
    .raddr_b(oper_addr), .rdata_b(oper_word)
  );

  acc_cpu_mult #(.W(MW)) mult_i (
    .clk(clk), .rst(rst), .start(mul_start),
    .a(acc_o[MW-1:0]), .b(oper_word[MW-1:0]),
    .busy(mul_busy), .done(mul_done), .prod(mul_prod)
  );

  acc_cpu_ctrl #(.DW(DW), .AW(AW), .MW(MW)) ctrl_i (
    .clk(clk), .rst(rst), .fetch_word(fetch_word), .oper_word(oper_word),
    .mul_done(mul_done), .mul_prod(mul_prod),
    .pc(pc_o), .oper_addr(oper_addr), .acc(acc_o), .halted(halted_o),
    .mem_we(core_we), .mul_start(mul_start)
  );

  // R10
  one_writer_chk: assert property (@(posedge clk)
    !(pre_we && core_we && !rst));
  // R7
  stall_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mul_busy |-> !halted_o);
endmodule

// File: tb/acc_cpu_top_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] acc_o;
  logic [7:0]  pc_o;
  logic        halted_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit seen = 1'b0;

  logic [15:0] q_acc[$];
  logic [7:0]  q_pc[$];
  int          q_cyc[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  acc_cpu_top dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .acc_o(acc_o), .pc_o(pc_o), .halted_o(halted_o)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item when the program halts
  always @(negedge clk) begin
    if (!rst && halted_o && !seen && q_acc.size() > 0) begin
      logic [15:0] ea;
      logic [7:0]  ep;
      int          ec;
      string       et;
      seen = 1'b1;
      ea = q_acc.pop_front();
      ep = q_pc.pop_front();
      ec = q_cyc.pop_front();
      et = q_tag.pop_front();
      check({et, " acc"}, {16'h0, acc_o}, {16'h0, ea});
      check({et, " pc"}, {24'h0, pc_o}, {24'h0, ep});
      check("R8 cycles to halt", cyc, ec);
    end
  end

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset acc", {16'h0, acc_o}, 32'h0);
    check("R1 reset pc", {24'h0, pc_o}, 32'h1);
    check("R1 reset halted", {31'h0, halted_o}, 32'h0);
    check("R10 ready in reset", {31'h0, ld_ready}, 32'h1);
  endtask

  task automatic w(input logic [7:0] a, input logic [15:0] d);
    ld_valid = 1'b1;
    ld_addr  = a;
    ld_data  = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // driver: pushes the expectation, then runs the program
  task automatic go(input string tag, input logic [15:0] ea, input logic [7:0] ep,
                    input int ec, input bit poke);
    int n;
    q_acc.push_back(ea);
    q_pc.push_back(ep);
    q_cyc.push_back(ec);
    q_tag.push_back(tag);
    seen = 1'b0;
    rst = 1'b0;
    if (poke) begin
      ld_valid = 1'b1;
      ld_addr  = 8'h20;
      ld_data  = 16'h0100;
      @(negedge clk);
      check("R10 ready low when running", {31'h0, ld_ready}, 32'h0);
      repeat (2) @(negedge clk);
      ld_valid = 1'b0;
    end
    n = 0;
    while (!seen && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!seen) begin
      errors++;
      checks++;
      $display("FAIL %s watchdog actual=running expected=halted", tag);
    end else begin
      repeat (5) @(negedge clk);
      check("R6 pc frozen", {24'h0, pc_o}, {24'h0, ep});
      check("R6 acc frozen", {16'h0, acc_o}, {16'h0, ea});
      check("R6 halted held", {31'h0, halted_o}, 32'h1);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL global watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // P1: R2 R3 R4 R5 - load, add, or, store, neg, wrap to zero, jumpz taken
    begin_prog();
    w(8'h20, 16'h0012); w(8'h21, 16'h0034); w(8'h22, 16'h0F00);
    w(8'h01, 16'h2005); w(8'h02, 16'h2101); w(8'h03, 16'h2202);
    w(8'h04, 16'h2306); w(8'h05, 16'hFF0A); w(8'h06, 16'h2301);
    w(8'h07, 16'h0904); w(8'h08, 16'h2205); w(8'h09, 16'h2105);
    w(8'h0A, 16'h0A03);
    go("R2 R3 R4 R5 alu and jumpz-taken", 16'h0034, 8'h0A, 18, 1'b0);

    // P2: R5 R9 R10 - jumpz not taken, unknown opcode, far jump, dropped preload
    begin_prog();
    w(8'h20, 16'h0005); w(8'h21, 16'h0999);
    w(8'h01, 16'h2005); w(8'h02, 16'h0604); w(8'h03, 16'h2077);
    w(8'h04, 16'h0703); w(8'h05, 16'h2105); w(8'h06, 16'h2105);
    w(8'h07, 16'h2001); w(8'h08, 16'h0803);
    go("R5 R9 R10 jumps, no-op, dropped word", 16'h000A, 8'h08, 12, 1'b1);

    // P3: R7 - low bytes only, 0x12 * 0xFD
    begin_prog();
    w(8'h20, 16'hAB12); w(8'h21, 16'h77FD);
    w(8'h01, 16'h2005); w(8'h02, 16'h2109); w(8'h03, 16'h0303);
    go("R7 multiply low bytes", 16'h11CA, 8'h03, 15, 1'b0);

    // P4: R7 R4 - 0xFF * 0xFF then negate
    begin_prog();
    w(8'h20, 16'h00FF);
    w(8'h01, 16'h2005); w(8'h02, 16'h2009); w(8'h03, 16'h2206);
    w(8'h04, 16'h000A); w(8'h05, 16'h0503);
    go("R7 R4 max product negated", 16'h01FF, 8'h05, 19, 1'b0);

    // P5: R3 - store overwrites the next instruction before it is fetched
    begin_prog();
    w(8'h20, 16'h2105); w(8'h21, 16'h2222); w(8'h22, 16'h1111);
    w(8'h01, 16'h2005); w(8'h02, 16'h0306); w(8'h03, 16'h2205);
    w(8'h04, 16'h0403);
    go("R3 store then fetch same word", 16'h2222, 8'h04, 8, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule